// File: doc/BRIEF.md
# Segment Bank Controller with Video Wait States

This block sits beside a 16-bit-address CPU bus and decides, for every memory access, whether an internal 64 KB RAM answers or whether the access goes on to the standard devices or to an external memory expansion. An 8-bit control register drives the decision. Software writes it through a serial bit-addressed I/O port, either one bit at a time or all eight bits in one load. The register's reset value of zero gives the usual machine layout: internal RAM answers only in the two windows where a standard 32 KB expansion normally lives.

The address space is split into eight 8 KB segments. The five lowest segments each have their own control bit. The three top segments (>A000–>FFFF) share one bit. For the two normally-RAM windows the bit sense is inverted, so setting the bit removes internal RAM and lets an external expansion respond. For every other segment, setting the bit pages internal RAM over ROM or the device area. One further bit adds wait states to accesses in the video port window. The block also sets the access length through a ready signal: internal RAM accesses are short and all other accesses are long.

Top module: `seg_bank_ctrl`

## Requirements
- R1: After reset all eight control bits read back as 0. Internal RAM is selected exactly for addresses >2000–>3FFF and >A000–>FFFF.
- R2: A single-bit write (`bit_we`) sets control bit `bit_sel` to `bit_wd` and leaves the other bits unchanged. `rd_bit` always returns control bit `bit_sel`.
- R3: A load (`load_we`) writes all eight bits from `load_data`. When a single-bit write happens in the same cycle, the single-bit value wins for its own bit.
- R4: Segment `addr[15:13]` = 0..4 is governed by control bit 0..4, and segments 5..7 by bit 5. The segment is internal RAM when its bit is 1, except for bits 1 and 5, where it is internal RAM when the bit is 0.
- R5: With control value 8'h1D, every address selects internal RAM, which gives a contiguous 64 KB.
- R6: During an access, `ext_en` is always the complement of `ram_sel`.
- R7: An access to internal RAM asserts `ready` in its second cycle.
- R8: An access that does not select internal RAM asserts `ready` in its sixth cycle, unless R9 applies.
- R9: When control bit 6 is 1 and the access falls in >8800–>8FFF without selecting internal RAM, `ready` comes in the tenth cycle (four extra cycles). When bit 6 is 0, such an access takes six cycles.
- R10: Control bit 7 has no effect on decode or timing, but it reads back as written.
- R11: `ready` is high only while `mem_req` is high. A new access starts its cycle count from the first cycle after the previous one completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_sel | input | 3 | Bit address for single-bit write and read |
| bit_we | input | 1 | Single-bit write strobe |
| bit_wd | input | 1 | Single-bit write value |
| load_we | input | 1 | Whole-register load strobe |
| load_data | input | 8 | Whole-register load value |
| rd_bit | output | 1 | Read-back of the addressed control bit |
| mem_req | input | 1 | CPU access in progress, held until ready |
| mem_addr | input | 16 | CPU address |
| ram_sel | output | 1 | Internal RAM select |
| ext_en | output | 1 | Pass-through enable to devices or expansion |
| ready | output | 1 | Access completes this cycle |

## Verification
On every cycle, the assertions check that the two selects are exclusive during an access, that `ready` never appears without a request, that an internal access completes on its second cycle, that slow accesses never complete early, and that each register write lands with the right precedence. The per-segment map under many control values, the full 64 KB layout, the exact ten-cycle video wait and the read-back of the unused bit are only shown by the bench's scenarios. The bench compares these against its own model.

// File: rtl/seg_bank_pkg.sv
// Shared constants for the segment bank controller.
// Assumes an 8-bit control register and eight 8 KB address segments.
package seg_bank_pkg;
    localparam int CTRL_W   = 8;
    localparam int SEG_CNT  = 8;
    localparam int SEG_BITS = 6;            // control bits that govern segments
    localparam int WAIT_BIT = 6;            // video wait-state enable
    // Bits whose sense is inverted (normally-RAM windows): bit 1 and bit 5
    localparam logic [SEG_BITS-1:0] INV_MASK = 6'b100010;

    // Map a segment number to the control bit that governs it
    function automatic int seg_ctrl_idx(input int seg);
        return (seg < SEG_BITS - 1) ? seg : SEG_BITS - 1;
    endfunction
endpackage

// File: rtl/seg_ctrl_reg.sv
// Control register written one bit at a time or loaded as a whole.
// Assumes a single-bit write overrides a same-cycle load for its own bit.
module seg_ctrl_reg #(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [$clog2(W)-1:0] bit_sel,
    input  logic                 bit_we,
    input  logic                 bit_wd,
    input  logic                 load_we,
    input  logic [W-1:0]         load_data,
    output logic [W-1:0]         ctrl_q,
    output logic                 rd_bit
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Hold one control bit; single-bit write takes priority over load
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctrl_q[i] <= 1'b0;
            else if (bit_we && (bit_sel == i[$clog2(W)-1:0]))
                ctrl_q[i] <= bit_wd;
            else if (load_we)
                ctrl_q[i] <= load_data[i];
        end
    end

    // Return the addressed bit for serial read-back
    always_comb rd_bit = ctrl_q[bit_sel];
endmodule

// File: rtl/seg_decode.sv
// Address decode: picks internal RAM per 8 KB segment and flags the video window.
// Assumes the control bits are stable during an access.
module seg_decode
    import seg_bank_pkg::*;
#(
    parameter logic [15:0] VID_BASE = 16'h8800,
    parameter logic [15:0] VID_MASK = 16'hF800
) (
    input  logic [SEG_BITS-1:0] seg_ctrl,
    input  logic [15:0]         addr,
    output logic                ram_sel,
    output logic                vid_hit
);
    localparam int SEG_SH = 16 - $clog2(SEG_CNT);

    logic [SEG_CNT-1:0] seg_en;

    for (genvar s = 0; s < SEG_CNT; s++) begin : g_seg
        localparam int IDX = seg_ctrl_idx(s);
        // A segment is RAM when its bit differs from the inversion mask
        always_comb seg_en[s] = seg_ctrl[IDX] ^ INV_MASK[IDX];
    end

    // Select the enable of the segment addressed now
    always_comb ram_sel = seg_en[addr[15:SEG_SH]];

    // Detect the video port window
    always_comb vid_hit = ((addr & VID_MASK) == VID_BASE);
endmodule

// File: rtl/seg_wait_gen.sv
// Ready generator: counts the cycles of an access and raises ready on the last one.
// Assumes mem_req stays high until ready, and restarts after each completion.
module seg_wait_gen #(
    parameter int FAST_CYC  = 2,
    parameter int SLOW_CYC  = 6,
    parameter int VID_EXTRA = 4,
    localparam int CNT_W    = $clog2(SLOW_CYC + VID_EXTRA + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             fast,
    input  logic             vid_wait,
    output logic             ready,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'(FAST_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'(SLOW_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_VID  = CNT_W'(SLOW_CYC + VID_EXTRA - 1);

    logic [CNT_W-1:0] last;

    // Choose the final cycle index for the current access kind
    always_comb begin
        if (fast)          last = LAST_FAST;
        else if (vid_wait) last = LAST_VID;
        else               last = LAST_SLOW;
    end

    // Complete the access when the count reaches the final index
    always_comb ready = req && (cnt_q == last);

    // Advance the count during an access, clear it when idle or done
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (req && !ready)
            cnt_q <= cnt_q + 1'b1;
        else
            cnt_q <= '0;
    end
endmodule

// File: rtl/seg_bank_ctrl.sv
// Top: segment bank controller with bit-addressed control register,
// per-segment RAM decode and video wait-state insertion.
// Assumes the CPU holds mem_req and mem_addr until ready.
module seg_bank_ctrl
    import seg_bank_pkg::*;
#(
    parameter int          FAST_CYC  = 2,
    parameter int          SLOW_CYC  = 6,
    parameter int          VID_EXTRA = 4,
    parameter logic [15:0] VID_BASE  = 16'h8800,
    parameter logic [15:0] VID_MASK  = 16'hF800
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bit_sel,
    input  logic        bit_we,
    input  logic        bit_wd,
    input  logic        load_we,
    input  logic [7:0]  load_data,
    output logic        rd_bit,
    input  logic        mem_req,
    input  logic [15:0] mem_addr,
    output logic        ram_sel,
    output logic        ext_en,
    output logic        ready
);
    localparam int CNT_W = $clog2(SLOW_CYC + VID_EXTRA + 1);

    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              vid_hit;

    seg_ctrl_reg #(.W(CTRL_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .bit_sel(bit_sel), .bit_we(bit_we),
        .bit_wd(bit_wd), .load_we(load_we), .load_data(load_data),
        .ctrl_q(ctrl_q), .rd_bit(rd_bit)
    );

    seg_decode #(.VID_BASE(VID_BASE), .VID_MASK(VID_MASK)) u_dec (
        .seg_ctrl(ctrl_q[SEG_BITS-1:0]), .addr(mem_addr),
        .ram_sel(ram_sel), .vid_hit(vid_hit)
    );

    seg_wait_gen #(.FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC), .VID_EXTRA(VID_EXTRA)) u_wait (
        .clk(clk), .rst_n(rst_n), .req(mem_req), .fast(ram_sel),
        .vid_wait(vid_hit && ctrl_q[WAIT_BIT]), .ready(ready), .cnt_q(cnt_q)
    );

    // Pass the access on whenever internal RAM does not take it
    always_comb ext_en = !ram_sel;
endmodule

// File: rtl/seg_bank_chk.sv
// Checker for seg_bank_ctrl, bound to every instance of the top.
module seg_bank_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       bit_sel,
    input logic             bit_we,
    input logic             bit_wd,
    input logic             load_we,
    input logic [7:0]       load_data,
    input logic             mem_req,
    input logic             ram_sel,
    input logic             ext_en,
    input logic             ready,
    input logic [7:0]       ctrl_q,
    input logic [CNT_W-1:0] cnt_q
);
    a_r2_bit_write: assert property (@(posedge clk) disable iff (!rst_n)
        bit_we |=> ctrl_q[$past(bit_sel)] == $past(bit_wd));

    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load_we && !bit_we) |=> ctrl_q == $past(load_data));

    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (ram_sel != ext_en));

    a_r7_fast_done: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && ram_sel && cnt_q == 1) |-> ready);

    a_r8_slow_not_early: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !ram_sel && cnt_q < 5) |-> !ready);

    a_r11_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> mem_req);
endmodule

bind seg_bank_ctrl seg_bank_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_sel(bit_sel), .bit_we(bit_we),
    .bit_wd(bit_wd), .load_we(load_we), .load_data(load_data),
    .mem_req(mem_req), .ram_sel(ram_sel), .ext_en(ext_en), .ready(ready),
    .ctrl_q(ctrl_q), .cnt_q(cnt_q)
);

// File: tb/test_seg_bank_ctrl.sv
module test_seg_bank_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bit_sel = '0;
    logic        bit_we = 1'b0, bit_wd = 1'b0, load_we = 1'b0;
    logic [7:0]  load_data = '0;
    logic        rd_bit, mem_req = 1'b0, ram_sel, ext_en, ready;
    logic [15:0] mem_addr = '0;

    int n_chk = 0, n_fail = 0;
    logic [7:0] model = '0;

    always #5 clk = ~clk;

    seg_bank_ctrl i_seg_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .bit_sel(bit_sel), .bit_we(bit_we),
        .bit_wd(bit_wd), .load_we(load_we), .load_data(load_data),
        .rd_bit(rd_bit), .mem_req(mem_req), .mem_addr(mem_addr),
        .ram_sel(ram_sel), .ext_en(ext_en), .ready(ready)
    );

    function automatic bit exp_ram(input logic [7:0] c, input logic [15:0] a);
        int s = int'(a[15:13]);
        int i = (s < 5) ? s : 5;
        bit inv = (i == 1) || (i == 5);
        return c[i] ^ inv;
    endfunction

    function automatic int exp_cyc(input logic [7:0] c, input logic [15:0] a);
        if (exp_ram(c, a)) return 2;
        if (c[6] && a[15:11] == 5'b10001) return 10;
        return 6;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_bit(input int i, input bit v);
        @(negedge clk); bit_sel = 3'(i); bit_wd = v; bit_we = 1'b1;
        @(negedge clk); bit_we = 1'b0;
        model[i] = v;
    endtask

    task automatic wr_all(input logic [7:0] v);
        @(negedge clk); load_data = v; load_we = 1'b1;
        @(negedge clk); load_we = 1'b0;
        model = v;
    endtask

    // One access; checks select, exclusivity and cycle count
    task automatic access(input string req, input logic [15:0] a);
        int n = 0;
        bit rs;
        @(negedge clk); mem_addr = a; mem_req = 1'b1;
        forever begin
            #1; n++;
            rs = ram_sel;
            if (ext_en == ram_sel) check("R6", int'(ext_en), int'(!ram_sel));
            if (ready || n > 40) break;
            @(negedge clk);
        end
        check(req, int'(rs), int'(exp_ram(model, a)));
        check(req, n, exp_cyc(model, a));
        @(negedge clk); mem_req = 1'b0;
        #1; check("R11", int'(ready), 0);
    endtask

    task automatic rd_check(input string req, input int i);
        @(negedge clk); bit_sel = 3'(i); #1;
        check(req, int'(rd_bit), int'(model[i]));
    endtask

    initial begin
        #2000000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int i = 0; i < 8; i++) rd_check("R1", i);
        for (int s = 0; s < 8; s++) access("R1", 16'(s * 16'h2000 + 16'h0100));
        // R2: single-bit writes
        wr_bit(0, 1'b1); rd_check("R2", 0); rd_check("R2", 1);
        access("R4", 16'h0010);
        wr_bit(5, 1'b1); access("R4", 16'hC000); rd_check("R2", 5);
        // R3: load with simultaneous bit write
        @(negedge clk); load_data = 8'hFF; load_we = 1'b1;
        bit_sel = 3'd2; bit_wd = 1'b0; bit_we = 1'b1;
        @(negedge clk); load_we = 1'b0; bit_we = 1'b0;
        model = 8'hFB;
        for (int i = 0; i < 8; i++) rd_check("R3", i);
        // R5: full 64 KB
        wr_all(8'h1D);
        for (int s = 0; s < 8; s++) access("R5", 16'(s * 16'h2000 + 16'h1234));
        // R9: video window with and without wait bit
        wr_all(8'h40); access("R9", 16'h8C00); access("R9", 16'h8800);
        access("R8", 16'h9000);
        wr_all(8'h00); access("R9", 16'h8C00);
        wr_all(8'h50); access("R9", 16'h8C00);
        // R10: bit 7 only reads back
        wr_all(8'h80); rd_check("R10", 7);
        access("R10", 16'h2000); access("R10", 16'h4000); access("R10", 16'hE000);
        // R7/R8: random mix
        for (int k = 0; k < 60; k++) begin
            if ($urandom_range(0, 3) == 0) wr_all(8'($urandom));
            else if ($urandom_range(0, 2) == 0) wr_bit(int'($urandom_range(0, 7)), 1'($urandom));
            access("R7_R8", 16'($urandom));
        end
        rd_check("R2", 6);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule